// File: doc/BRIEF.md
# Degradable Triple-Redundant Result Voter

This block takes the byte-wide results of three identical units that work on the same input. It turns them into one system result. While all three units are in service, every bit of the result is taken as a two-of-three majority. The unit that disagrees is named, so one faulty unit is masked and its output is corrected.

A supervisor that watches the units can take a suspect unit out of service with a lockout request. Once a unit is locked out, the block compares the two remaining units. In that state it can detect a disagreement but cannot correct it. After one more lockout it passes the last unit straight through. If all three units are locked out, the output is forced to zero and a fault is raised.

Along with the voted word, the block reports which units it suspects, whether the active units disagreed, its operating mode, a registered copy of every raw result and a saturating count of disagreements per unit. With these outputs, faults hidden behind the majority can still be observed and tested.

Top module: `tmr_degrade_voter`

## Requirements
- R1: A synchronous reset clears the outputs. Afterwards the voted word, suspect flags, mismatch, fault, taps and counters are all zero and the mode is triple (00).
- R2: The outputs are registered with one cycle of latency. In triple mode, when all three results are equal, the voted word is that value, no unit is suspected and mismatch is low.
- R3: In triple mode each bit of the voted word is the majority of the three results. Suspect bit i (bit 0 = unit A, bit 1 = unit B, bit 2 = unit C) is set when unit i differs from the voted word in any bit. Mismatch is set when any unit is suspected.
- R4: If two units agree on a wrong value, the voted word follows that pair and only the third unit is suspected. This case is not reported as a fault.
- R5: The lockout request is a 3-bit mask, bit i for unit i. It is ORed into a sticky lock state that only reset clears. A request also governs the result sampled in the same cycle.
- R6: With exactly one unit locked, the mode is duplex (01). The voted word comes from the lower-indexed active unit, and mismatch is set when the two active units differ. No unit is suspected.
- R7: With exactly two units locked, the mode is simplex (10). The voted word is the remaining unit's result, with no mismatch and no suspect.
- R8: With all three units locked, the mode is 11, the voted word is zero and fault is high. Fault is low in every other mode.
- R9: The tap output holds each raw result registered one cycle: A in bits 7:0, B in 15:8 and C in 23:16. This holds even for locked units.
- R10: Each unit has a disagreement counter, laid out like the taps. It increments in the same cycle its suspect flag is set and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req | input | 3 | Lockout request mask, bit i for unit i |
| res_a | input | 8 | Result of unit A |
| res_b | input | 8 | Result of unit B |
| res_c | input | 8 | Result of unit C |
| vote_q | output | 8 | Registered system result |
| suspect_q | output | 3 | Units that disagreed with the majority |
| mismatch_q | output | 1 | Active units disagreed |
| fault_q | output | 1 | All units locked out |
| mode_q | output | 2 | 00 triple, 01 duplex, 10 simplex, 11 none |
| tap_q | output | 24 | Registered raw results {C, B, A} |
| cnt_q | output | 24 | Disagreement counters {C, B, A} |

## Verification
The hardest state to reach is a saturated counter: one unit must be outvoted for more than 255 consecutive samples. The stimulus does this by holding unit A one bit away from the other two for 300 cycles, then checking that the count stops at 255. The step-down path is also exercised in detail. Lockout requests are pulsed only once, later samples are driven with no request, and the locked units carry deliberately wrong data. This shows that the lock state is held and that locked results never reach the voted word. A reset in the middle of the run, followed by a double lockout in a single request, covers the jump from triple mode straight to simplex.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;

    localparam int UNITS = 3;

    typedef enum logic [1:0] {
        MODE_TRIPLE  = 2'b00,
        MODE_DUPLEX  = 2'b01,
        MODE_SIMPLEX = 2'b10,
        MODE_DEAD    = 2'b11
    } vmode_e;

    typedef struct packed {
        logic [UNITS-1:0] suspect;
        logic             mismatch;
        logic             fault;
        vmode_e           mode;
    } vflags_t;

    function automatic vmode_e mode_of(input logic [UNITS-1:0] lk);
        case (lk)
            3'b000:                 return MODE_TRIPLE;
            3'b001, 3'b010, 3'b100: return MODE_DUPLEX;
            3'b011, 3'b101, 3'b110: return MODE_SIMPLEX;
            default:                return MODE_DEAD;
        endcase
    endfunction

endpackage

// File: rtl/tmr_lock_mask.sv
module tmr_lock_mask
    import tmr_voter_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [UNITS-1:0] req,
    output logic [UNITS-1:0] eff,
    output logic [UNITS-1:0] lock_q
);

    assign eff = lock_q | req;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= '0;
        else     lock_q <= eff;
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_q) & ~lock_q) == '0);

endmodule

// File: rtl/tmr_vote_core.sv
module tmr_vote_core
    import tmr_voter_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [UNITS-1:0][WIDTH-1:0] res,
    input  logic [UNITS-1:0]            lock,
    output logic [WIDTH-1:0]            word,
    output vflags_t                     flags
);

    logic [WIDTH-1:0] maj;
    logic [WIDTH-1:0] lo_word;
    logic [WIDTH-1:0] hi_word;
    logic             lo_found;
    logic [UNITS-1:0] differs;
    vmode_e           mode;

    assign maj  = (res[0] & res[1]) | (res[0] & res[2]) | (res[1] & res[2]);
    assign mode = mode_of(lock);

    for (genvar g = 0; g < UNITS; g++) begin : g_diff
        assign differs[g] = |(res[g] ^ maj);
    end

    // Pick the lowest and next active unit for duplex/simplex paths.
    always_comb begin
        lo_word  = '0;
        hi_word  = '0;
        lo_found = 1'b0;
        for (int i = 0; i < UNITS; i++) begin
            if (!lock[i]) begin
                if (!lo_found) begin
                    lo_word  = res[i];
                    lo_found = 1'b1;
                end else begin
                    hi_word = res[i];
                end
            end
        end
    end

    always_comb begin
        word           = '0;
        flags.suspect  = '0;
        flags.mismatch = 1'b0;
        flags.fault    = 1'b0;
        flags.mode     = mode;
        case (mode)
            MODE_TRIPLE: begin
                word           = maj;
                flags.suspect  = differs;
                flags.mismatch = |differs;
            end
            MODE_DUPLEX: begin
                word           = lo_word;
                flags.mismatch = |(lo_word ^ hi_word);
            end
            MODE_SIMPLEX: begin
                word = lo_word;
            end
            default: begin
                word        = '0;
                flags.fault = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tmr_sat_counters.sv
module tmr_sat_counters
    import tmr_voter_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [UNITS-1:0]            hit,
    output logic [UNITS-1:0][CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar g = 0; g < UNITS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)                              cnt[g] <= '0;
            else if (hit[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + 1'b1;
        end

        // R10
        cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
            cnt[g] >= $past(cnt[g]));

        // R10
        cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
            cnt[g] == CNT_MAX |=> cnt[g] == CNT_MAX);
    end

endmodule

// File: rtl/tmr_degrade_voter.sv
module tmr_degrade_voter
    import tmr_voter_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CNT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [UNITS-1:0]         lock_req,
    input  logic [WIDTH-1:0]         res_a,
    input  logic [WIDTH-1:0]         res_b,
    input  logic [WIDTH-1:0]         res_c,
    output logic [WIDTH-1:0]         vote_q,
    output logic [UNITS-1:0]         suspect_q,
    output logic                     mismatch_q,
    output logic                     fault_q,
    output logic [1:0]               mode_q,
    output logic [UNITS*WIDTH-1:0]   tap_q,
    output logic [UNITS*CNT_W-1:0]   cnt_q
);

    logic [UNITS-1:0][WIDTH-1:0] res;
    logic [UNITS-1:0]            lock_eff;
    logic [UNITS-1:0]            lock_q;
    logic [WIDTH-1:0]            word_d;
    vflags_t                     flags_d;
    vflags_t                     flags_q;
    logic [UNITS-1:0][CNT_W-1:0] cnt;
    logic [UNITS-1:0][WIDTH-1:0] tap_r;

    assign res = {res_c, res_b, res_a};

    tmr_lock_mask u_lock (
        .clk    (clk),
        .rst    (rst),
        .req    (lock_req),
        .eff    (lock_eff),
        .lock_q (lock_q)
    );

    tmr_vote_core #(.WIDTH(WIDTH)) u_core (
        .res   (res),
        .lock  (lock_eff),
        .word  (word_d),
        .flags (flags_d)
    );

    tmr_sat_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .hit (flags_d.suspect),
        .cnt (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vote_q  <= '0;
            flags_q <= '{suspect: '0, mismatch: 1'b0, fault: 1'b0, mode: MODE_TRIPLE};
            tap_r   <= '0;
        end else begin
            vote_q  <= word_d;
            flags_q <= flags_d;
            tap_r   <= res;
        end
    end

    assign suspect_q  = flags_q.suspect;
    assign mismatch_q = flags_q.mismatch;
    assign fault_q    = flags_q.fault;
    assign mode_q     = flags_q.mode;
    assign tap_q      = tap_r;
    assign cnt_q      = cnt;

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> vote_q == '0);

    // R6
    suspect_triple_only_chk: assert property (@(posedge clk) disable iff (rst)
        (|suspect_q) |-> mode_q == MODE_TRIPLE);

    // R5
    suspect_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (suspect_q & lock_q) == '0);

    // R2
    agree_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_eff) == '0 && $past(res_a) == $past(res_b) && $past(res_b) == $past(res_c))
            |-> (vote_q == $past(res_a) && !mismatch_q));

    // R9
    tap_latency_chk: assert property (@(posedge clk) disable iff (rst)
        tap_q[WIDTH-1:0] == $past(res_a));

    // R7
    simplex_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_SIMPLEX |-> !mismatch_q && !fault_q);

endmodule

// File: tb/tb_tmr_degrade_voter.sv
`timescale 1ns/1ps
module tb_tmr_degrade_voter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  lock_req = '0;
    logic [7:0]  res_a = '0, res_b = '0, res_c = '0;
    logic [7:0]  vote_q;
    logic [2:0]  suspect_q;
    logic        mismatch_q, fault_q;
    logic [1:0]  mode_q;
    logic [23:0] tap_q, cnt_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_lock;
    int m_cnt [3];

    always #5 clk = ~clk;

    tmr_degrade_voter dut (
        .clk(clk), .rst(rst), .lock_req(lock_req),
        .res_a(res_a), .res_b(res_b), .res_c(res_c),
        .vote_q(vote_q), .suspect_q(suspect_q), .mismatch_q(mismatch_q),
        .fault_q(fault_q), .mode_q(mode_q), .tap_q(tap_q), .cnt_q(cnt_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; lock_req = '0; res_a = '0; res_b = '0; res_c = '0;
        repeat (2) @(posedge clk);
        #1;
        m_lock = 0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
        chk("R1", "vote", vote_q, 0);
        chk("R1", "suspect", suspect_q, 0);
        chk("R1", "mismatch", mismatch_q, 0);
        chk("R1", "fault", fault_q, 0);
        chk("R1", "mode", mode_q, 0);
        chk("R1", "tap", tap_q, 0);
        chk("R1", "cnt", cnt_q, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Behavioural reference: one sample per call, compared one edge later.
    task automatic step(input int a, input int b, input int c, input int lk, input string tag);
        int r [3];
        int act_n, first, second, ones;
        int e_vote, e_sus, e_mis, e_fault, e_mode;
        r[0] = a; r[1] = b; r[2] = c;
        @(negedge clk);
        res_a = a[7:0]; res_b = b[7:0]; res_c = c[7:0]; lock_req = lk[2:0];
        @(posedge clk);
        #1;
        m_lock = m_lock | lk;
        act_n = 0; first = -1; second = -1;
        for (int i = 0; i < 3; i++) begin
            if (((m_lock >> i) & 1) == 0) begin
                act_n++;
                if (first < 0) first = i; else second = i;
            end
        end
        e_vote = 0; e_sus = 0; e_mis = 0; e_fault = 0;
        if (act_n == 3) begin
            e_mode = 0;
            for (int bt = 0; bt < 8; bt++) begin
                ones = ((a >> bt) & 1) + ((b >> bt) & 1) + ((c >> bt) & 1);
                if (ones >= 2) e_vote |= (1 << bt);
            end
            for (int i = 0; i < 3; i++) if (r[i] != e_vote) e_sus |= (1 << i);
            e_mis = (e_sus != 0);
        end else if (act_n == 2) begin
            e_mode = 1;
            e_vote = r[first];
            e_mis  = (r[first] != r[second]);
        end else if (act_n == 1) begin
            e_mode = 2;
            e_vote = r[first];
        end else begin
            e_mode = 3;
            e_fault = 1;
        end
        for (int i = 0; i < 3; i++)
            if (((e_sus >> i) & 1) && m_cnt[i] < 255) m_cnt[i]++;
        chk(tag, "vote", vote_q, e_vote);
        chk(tag, "suspect", suspect_q, e_sus);
        chk(tag, "mismatch", mismatch_q, e_mis);
        chk(tag, "fault", fault_q, e_fault);
        chk(tag, "mode", mode_q, e_mode);
        chk("R9", "tap", tap_q, (c << 16) | (b << 8) | a);
        chk("R10", "cnt", cnt_q, (m_cnt[2] << 16) | (m_cnt[1] << 8) | m_cnt[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();                               // R1
        // R2: unanimous results
        step('h00, 'h00, 'h00, 0, "R2");
        step('hFF, 'hFF, 'hFF, 0, "R2");
        step('hA5, 'hA5, 'hA5, 0, "R2");
        step('h3C, 'h3C, 'h3C, 0, "R2");
        // R3: single odd unit and split bits
        step('h5A, 'h55, 'h55, 0, "R3");
        step('h55, 'h5A, 'h55, 0, "R3");
        step('h55, 'h55, 'hAA, 0, "R3");
        step('h01, 'h80, 'h00, 0, "R3");
        step('hF0, 'h0F, 'h3C, 0, "R3");
        // R4: two units agree on a wrong value
        step('hFF, 'hFF, 'h00, 0, "R4");
        // R10: drive unit A into saturation
        for (int k = 0; k < 300; k++) step('h01, 'h00, 'h00, 0, "R10");
        // R6: lock unit B, A is the lower active unit
        step('h11, 'h22, 'h11, 'b010, "R6");
        step('h11, 'hEE, 'h13, 0, "R6");
        step('h40, 'h00, 'h40, 0, "R5");
        // R7: lock A, C passes through
        step('h11, 'h22, 'h77, 'b001, "R7");
        step('h00, 'hFF, 'h9C, 0, "R7");
        step('hFF, 'h00, 'h01, 0, "R5");
        // R8: all locked
        step('hAA, 'hBB, 'hCC, 'b100, "R8");
        step('h12, 'h34, 'h56, 0, "R8");
        // R5: only reset clears the lock state
        do_reset();
        step('h66, 'h66, 'h66, 0, "R5");
        step('h81, 'h18, 'h00, 'b100, "R6");
        step('h81, 'h81, 'h00, 0, "R6");
        do_reset();
        step('h21, 'h43, 'h65, 'b011, "R7");
        step('h21, 'h43, 'h99, 0, "R7");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule